// File: doc/BRIEF.md
# Dual-Channel Serial Code Loader

This block is the digital front end of a two-channel 12-bit converter. A host sends a 24-bit frame one bit at a time on a serial clock and data pair while holding an active-low select. The frame fills one shared shift register. Two active-low strobes then copy each half of that register into the matching channel's code register. The strobes can be used one at a time or together. An active-low clear empties the shift register and both code registers immediately.

Every control input is slow compared with the system clock and may arrive with no timing relation to it. Each one passes through a synchronizer into the system clock domain. The serial clock and the two strobes act on their falling edges, which are detected after synchronization. A frame carries the second channel's code first, most significant bit first, and the first channel's code after it in the same order.

Top module: `dual_serial_dac_loader`

## Requirements
- R1: While `clr_n` is low, the shift register and both code outputs are all zeros, whatever the other inputs do. The reset takes effect without waiting for a clock edge.
- R2: With select low, each falling edge of the serial clock takes in the level on `sdin_i`. The new bit enters register position 23 and every earlier bit moves one position toward 0, so the first bit of a frame ends at position 0.
- R3: After 24 bits, the first 12 bits sent (most significant first) form the channel B code and the last 12 bits sent form the channel A code. Channel A's code has position 12 as its MSB and position 23 as its LSB. Channel B's code has position 0 as its MSB and position 11 as its LSB.
- R4: With select low, a falling edge on `upd_a_n_i` copies the channel A half into `code_a_o` and leaves `code_b_o` unchanged.
- R5: With select low, a falling edge on `upd_b_n_i` copies the channel B half into `code_b_o` and leaves `code_a_o` unchanged.
- R6: When both strobes fall together with select low, both code registers load in the same cycle.
- R7: With select high, serial clock edges and strobe edges have no effect: the shift register and both code registers keep their contents.
- R8: A strobe loads only once for each falling edge. Bits shifted in while a strobe is still held low do not reach that channel's code register.
- R9: A clear in the middle of a frame discards the bits already received. A load after the clear is released gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled in this domain |
| clr_n | input | 1 | Active-low asynchronous clear of all registers |
| sclk_i | input | 1 | Serial clock; a bit is taken on its falling edge |
| sdin_i | input | 1 | Serial data |
| cs_n_i | input | 1 | Active-low select; gates shifting and loading |
| upd_a_n_i | input | 1 | Active-low load strobe for channel A |
| upd_b_n_i | input | 1 | Active-low load strobe for channel B |
| code_a_o | output | 12 | Channel A code register |
| code_b_o | output | 12 | Channel B code register |

## Verification
The assertions assume that every input stays at one level for at least three system clock cycles. Under that assumption each falling edge is seen exactly once, and the data bit is stable when its serial clock edge is detected. They also assume that the clear is released only while the serial clock and the strobes are high. The stimulus holds every level for four or more cycles, changes inputs half a cycle away from the active edge, and releases the clear only with the serial clock, select and both strobes high. The frames are swept with a walking one across all 24 positions, its complement, and arithmetic pseudo-random patterns. The update kind rotates between A only, B only and both.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
    // Lanes of the input synchronizer bank
    localparam int LANE_SCLK  = 0;
    localparam int LANE_CS    = 1;
    localparam int LANE_UPA   = 2;
    localparam int LANE_UPB   = 3;
    localparam int LANE_DIN   = 4;
    localparam int NUM_LANES  = 5;
    // Idle level of each lane after clear: strobes, select and clock high, data low
    localparam logic [NUM_LANES-1:0] LANE_IDLE = 5'b01111;

    // Lanes of the falling-edge detector
    localparam int EDGE_SCLK  = 0;
    localparam int EDGE_UPA   = 1;
    localparam int EDGE_UPB   = 2;
    localparam int NUM_EDGES  = 3;
endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dsl_fall_det.sv
module dsl_fall_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        for (int i = 0; i < W; i++) begin
            fall_o[i] = prev_q[i] & ~level_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dsl_core.sv
module dsl_core #(
    parameter int CODE_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_act_i,
    input  logic                  shift_i,
    input  logic                  din_i,
    input  logic                  lda_i,
    input  logic                  ldb_i,
    output logic [2*CODE_W-1:0]   frame_o,
    output logic [CODE_W-1:0]     code_a_o,
    output logic [CODE_W-1:0]     code_b_o
);
    localparam int FRAME_W = 2 * CODE_W;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CODE_W-1:0]  code_a;
        logic [CODE_W-1:0]  code_b;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [CODE_W-1:0] half_a, half_b;

    always_comb begin
        // Position CODE_W is the A MSB and position 0 is the B MSB; the LSBs sit at the higher index
        for (int j = 0; j < CODE_W; j++) begin
            half_a[CODE_W-1-j] = st_q.frame[CODE_W+j];
            half_b[CODE_W-1-j] = st_q.frame[j];
        end
        st_d = st_q;
        if (cs_act_i) begin
            if (lda_i)   st_d.code_a = half_a;
            if (ldb_i)   st_d.code_b = half_b;
            if (shift_i) st_d.frame  = {din_i, st_q.frame[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o  = st_q.frame;
    assign code_a_o = st_q.code_a;
    assign code_b_o = st_q.code_b;
endmodule

// File: rtl/dual_serial_dac_loader.sv
module dual_serial_dac_loader
    import dsl_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              sclk_i,
    input  logic              sdin_i,
    input  logic              cs_n_i,
    input  logic              upd_a_n_i,
    input  logic              upd_b_n_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o
);
    localparam int FRAME_W = 2 * CODE_W;

    logic [NUM_LANES-1:0] raw_lanes, sync_lanes;
    logic [NUM_EDGES-1:0] edge_lvl, edge_fall;
    logic                 cs_act, sclk_fall, upa_fall, upb_fall;
    logic [FRAME_W-1:0]   frame_q;

    always_comb begin
        raw_lanes            = '0;
        raw_lanes[LANE_SCLK] = sclk_i;
        raw_lanes[LANE_CS]   = cs_n_i;
        raw_lanes[LANE_UPA]  = upd_a_n_i;
        raw_lanes[LANE_UPB]  = upd_b_n_i;
        raw_lanes[LANE_DIN]  = sdin_i;
    end

    dsl_sync #(
        .W       (NUM_LANES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LANE_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (clr_n),
        .async_i (raw_lanes),
        .sync_o  (sync_lanes)
    );

    always_comb begin
        edge_lvl            = '1;
        edge_lvl[EDGE_SCLK] = sync_lanes[LANE_SCLK];
        edge_lvl[EDGE_UPA]  = sync_lanes[LANE_UPA];
        edge_lvl[EDGE_UPB]  = sync_lanes[LANE_UPB];
    end

    dsl_fall_det #(
        .W       (NUM_EDGES)
    ) u_fall (
        .clk     (clk),
        .rst_n   (clr_n),
        .level_i (edge_lvl),
        .fall_o  (edge_fall)
    );

    assign cs_act    = ~sync_lanes[LANE_CS];
    assign sclk_fall = edge_fall[EDGE_SCLK];
    assign upa_fall  = edge_fall[EDGE_UPA];
    assign upb_fall  = edge_fall[EDGE_UPB];

    dsl_core #(
        .CODE_W   (CODE_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (clr_n),
        .cs_act_i (cs_act),
        .shift_i  (sclk_fall),
        .din_i    (sync_lanes[LANE_DIN]),
        .lda_i    (upa_fall),
        .ldb_i    (upb_fall),
        .frame_o  (frame_q),
        .code_a_o (code_a_o),
        .code_b_o (code_b_o)
    );
endmodule

// File: rtl/dsl_checker.sv
module dsl_checker #(
    parameter int CODE_W = 12
) (
    input logic                clk,
    input logic                clr_n,
    input logic                cs_act,
    input logic                shift_p,
    input logic                lda_p,
    input logic                ldb_p,
    input logic [2*CODE_W-1:0] frame,
    input logic [CODE_W-1:0]   code_a,
    input logic [CODE_W-1:0]   code_b
);
    localparam int FRAME_W = 2 * CODE_W;

    // R1: clear holds everything at zero
    a_r1_clear_zero: assert property (@(posedge clk)
        !clr_n |-> (frame == '0 && code_a == '0 && code_b == '0));

    // R2: a shift moves every bit one place toward position 0
    a_r2_shift_order: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_p && cs_act) |=> frame[FRAME_W-2:0] == $past(frame[FRAME_W-1:1]));

    // R7: select high freezes all state
    a_r7_cs_freeze: assert property (@(posedge clk) disable iff (!clr_n)
        !cs_act |=> ($stable(frame) && $stable(code_a) && $stable(code_b)));

    // R3/R4: A load takes MSB from position CODE_W and LSB from the top position
    a_r4_load_a_bits: assert property (@(posedge clk) disable iff (!clr_n)
        (lda_p && cs_act) |=> (code_a[CODE_W-1] == $past(frame[CODE_W]) &&
                               code_a[0] == $past(frame[FRAME_W-1])));

    // R3/R5: B load takes MSB from position 0 and LSB from position CODE_W-1
    a_r5_load_b_bits: assert property (@(posedge clk) disable iff (!clr_n)
        (ldb_p && cs_act) |=> (code_b[CODE_W-1] == $past(frame[0]) &&
                               code_b[0] == $past(frame[CODE_W-1])));

    // R4: channel A holds without its own load
    a_r4_a_holds: assert property (@(posedge clk) disable iff (!clr_n)
        !(lda_p && cs_act) |=> $stable(code_a));

    // R5: channel B holds without its own load
    a_r5_b_holds: assert property (@(posedge clk) disable iff (!clr_n)
        !(ldb_p && cs_act) |=> $stable(code_b));

    // R8: each strobe edge yields a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!clr_n)
        (lda_p || ldb_p) |=> !($past(lda_p) && lda_p) && !($past(ldb_p) && ldb_p));
endmodule

bind dual_serial_dac_loader dsl_checker #(.CODE_W(CODE_W)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .cs_act (cs_act),
    .shift_p(sclk_fall),
    .lda_p  (upa_fall),
    .ldb_p  (upb_fall),
    .frame  (frame_q),
    .code_a (code_a_o),
    .code_b (code_b_o)
);

// File: tb/sim_dual_serial_dac_loader.sv
module sim_dual_serial_dac_loader;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic clr_n = 1'b1;
    logic sclk = 1'b1, sdin = 1'b0, cs_n = 1'b1, upa_n = 1'b1, upb_n = 1'b1;
    logic [CW-1:0] code_a, code_b;
    logic [CW-1:0] exp_a = '0, exp_b = '0;
    logic [CW-1:0] reg_a = '0, reg_b = '0;   // expected halves held in the shift register
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    dual_serial_dac_loader #(.CODE_W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .clr_n(clr_n), .sclk_i(sclk), .sdin_i(sdin), .cs_n_i(cs_n),
        .upd_a_n_i(upa_n), .upd_b_n_i(upb_n), .code_a_o(code_a), .code_b_o(code_b)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_both(input string tag);
        check({tag, " chan A"}, code_a, exp_a);
        check({tag, " chan B"}, code_b, exp_b);
    endtask

    task automatic send_bit(input logic b);
        sdin = b;
        wait_n(3);
        sclk = 1'b0;
        wait_n(4);
        sclk = 1'b1;
        wait_n(4);
    endtask

    // B code first, MSB first; then A code, MSB first
    task automatic send_frame(input logic [CW-1:0] a, input logic [CW-1:0] b);
        for (int i = CW - 1; i >= 0; i--) send_bit(b[i]);
        for (int i = CW - 1; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic strobe(input logic do_a, input logic do_b);
        if (do_a) upa_n = 1'b0;
        if (do_b) upb_n = 1'b0;
        wait_n(5);
        upa_n = 1'b1;
        upb_n = 1'b1;
        wait_n(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2*CW-1:0] pat;
        logic [31:0] lcg;
        #1 clr_n = 1'b0;
        wait_n(4);
        check("R1 reset A", code_a, '0);
        check("R1 reset B", code_b, '0);
        clr_n = 1'b1;
        wait_n(3);
        cs_n = 1'b0;
        wait_n(4);

        // R2 R3 R4 R5 R6: sweep frames, rotating the update kind
        lcg = 32'h1357_9bdf;
        for (int k = 0; k < 60; k++) begin
            if (k < 24)      pat = 24'(1) << k;
            else if (k < 48) pat = ~(24'(1) << (k - 24));
            else begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                pat = lcg[27:4];
            end
            reg_a = pat[2*CW-1:CW];
            reg_b = pat[CW-1:0];
            send_frame(reg_a, reg_b);
            case (k % 3)
                0: begin strobe(1'b1, 1'b0); exp_a = reg_a; check_both("R4 A-only load"); end
                1: begin strobe(1'b0, 1'b1); exp_b = reg_b; check_both("R5 B-only load"); end
                default: begin
                    strobe(1'b1, 1'b1); exp_a = reg_a; exp_b = reg_b;
                    check_both("R6 dual load R3 mapping");
                end
            endcase
        end

        // R7: select high ignores a whole frame and both strobes
        strobe(1'b1, 1'b1);
        exp_a = reg_a; exp_b = reg_b;
        cs_n = 1'b1;
        wait_n(4);
        send_frame(12'h5a5, 12'hc3c);
        strobe(1'b1, 1'b1);
        check_both("R7 strobes ignored");
        cs_n = 1'b0;
        wait_n(4);
        strobe(1'b1, 1'b1);
        check_both("R7 shift register untouched");

        // R8: strobe held low while new bits arrive loads once only
        upa_n = 1'b0;
        wait_n(5);
        send_frame(12'h0f1, 12'h9e2);
        check("R8 held strobe no reload", code_a, exp_a);
        upa_n = 1'b1;
        wait_n(5);
        strobe(1'b1, 1'b0);
        exp_a = 12'h0f1;
        check("R8 next edge loads", code_a, exp_a);

        // R9 R1: clear in mid-frame
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        cs_n = 1'b1;
        wait_n(2);
        clr_n = 1'b0;
        wait_n(1);
        check("R1 clear A async", code_a, '0);
        check("R1 clear B async", code_b, '0);
        cs_n = 1'b0;
        upa_n = 1'b0;
        upb_n = 1'b0;
        wait_n(5);
        check("R1 clear priority A", code_a, '0);
        check("R1 clear priority B", code_b, '0);
        upa_n = 1'b1;
        upb_n = 1'b1;
        cs_n = 1'b1;
        wait_n(4);
        clr_n = 1'b1;
        wait_n(3);
        cs_n = 1'b0;
        wait_n(4);
        strobe(1'b1, 1'b1);
        exp_a = '0; exp_b = '0;
        check_both("R9 partial frame discarded");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule